// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits beside the command decoder of a serial NOR flash and decides whether each command may change anything. When chip select rises, the SPI front end presents five things: the opcode, the number of serial clocks seen in the frame, the 64 KB block index of the target address, the status bits proposed by a status write, and the level of the active-low write-protect pin. One cycle later the controller answers with a grant or a reject pulse. A granted program or erase also gets a start pulse for the array engines.

The controller holds the write-enable latch, the three area-protect bits and the status-lock bit. It also tracks deep power-down and counts out a power-up inhibit window after reset. A modifying command must clear every gate in turn:

- the latch is set;
- the frame length is valid;
- the inhibit window has ended;
- the part is not in deep power-down;
- the part is not busy;
- the target area is not protected;
- for a status write, the status bits are not locked.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset the write-enable latch, the area-protect bits, the status-lock bit and the deep power-down flag are 0, and no grant, reject or start pulse is asserted.
- R2: Each chip-select-rise event with a recognised opcode gives exactly one of grant or reject, one cycle later. Recognised opcodes are:
  - 0x06 enable;
  - 0x04 disable;
  - 0x01 status write;
  - 0x02 program;
  - 0x20 sector erase;
  - 0xD8 block erase;
  - 0x60 and 0xC7 chip erase;
  - 0xB9 power-down;
  - 0xAB release.

  Any other opcode gives neither pulse and changes no state.
- R3: A granted 0x06 sets the write-enable latch. The modifying commands are status write, program, sector erase, block erase and chip erase. Each is rejected while the latch is 0.
- R4: A granted disable, status write, program or erase clears the latch. A rejected command leaves the latch and the status bits unchanged.
- R5: Modifying commands are rejected until PUW_CYCLES clock cycles have passed since reset release.
- R6: A command is rejected unless its clock count is a multiple of 8 and at least its minimum length:
  - 16 for status write;
  - 32 for sector or block erase;
  - 40 for program;
  - 8 for all other commands.
- R7: A granted 0xB9 enters deep power-down. While in deep power-down every recognised opcode except 0xAB is rejected. A granted 0xAB leaves deep power-down.
- R8: While the busy input is 1, modifying commands are rejected.
- R9: The area-protect value B selects the protected blocks:
  - B=0 protects nothing;
  - B=7 protects the whole array;
  - any other B protects the top min(2^(B-1), block count) blocks.

  Program, sector erase and block erase to a protected block are rejected. Chip erase is rejected whenever B is nonzero.
- R10: A granted status write loads the area-protect bits from newBp and the status-lock bit from newSrwd. A status write is rejected while the status-lock bit is 1 and wpN is 0.
- R11: A granted program pulses progStart. A granted sector, block or chip erase pulses eraseStart, with eraseScope set to 0, 1 or 2 respectively. The start pulse comes in the same cycle as the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| csRise | input | 1 | One-cycle event: chip select rose, frame ended |
| opcode | input | 8 | Decoded first byte of the frame |
| bitCount | input | CNT_W | Serial clocks counted in the frame |
| blkAddr | input | BLK_W | 64 KB block index of the target address |
| newBp | input | 3 | Area-protect value carried by a status write |
| newSrwd | input | 1 | Status-lock value carried by a status write |
| wpN | input | 1 | Write-protect pin level, active low |
| busy | input | 1 | Array operation in progress |
| grant | output | 1 | Command accepted (pulse) |
| reject | output | 1 | Command refused (pulse) |
| progStart | output | 1 | Start page program (pulse) |
| eraseStart | output | 1 | Start erase (pulse) |
| eraseScope | output | 2 | Erase size: 0 sector, 1 block, 2 chip |
| wel | output | 1 | Write-enable latch |
| bpBits | output | 3 | Area-protect bits |
| srwd | output | 1 | Status-lock bit |
| deepPd | output | 1 | Deep power-down state |

## Verification
Every result of a frame lands exactly one cycle after the csRise edge. The decision pulses, the start pulses, the latch and the status fields all update at the same edge, and the pulses drop again one edge later. The bench raises csRise at a falling edge and drops it at the next falling edge, and samples all outputs at that second falling edge, so each check reads the registered result of exactly one frame. The inhibit window is checked on both sides: a program inside it is refused, and one sent after PUW_CYCLES plus a margin is granted.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERA = 8'h20;
  localparam logic [7:0] OP_BERA = 8'hD8;
  localparam logic [7:0] OP_CERA = 8'h60;
  localparam logic [7:0] OP_CERB = 8'hC7;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_REL  = 8'hAB;

  typedef enum logic [1:0] {
    SCOPE_SECTOR = 2'd0,
    SCOPE_BLOCK  = 2'd1,
    SCOPE_CHIP   = 2'd2
  } scope_e;

  typedef enum logic [3:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PROG, K_SERA, K_BERA, K_CERA, K_DPD, K_REL
  } kind_e;

  typedef struct packed {
    logic   grant;
    logic   reject;
    logic   setWel;
    logic   clrWel;
    logic   wrStatus;
    logic   enterDp;
    logic   exitDp;
    logic   prog;
    logic   erase;
    scope_e scope;
  } strobe_t;

  // Shortest legal frame, in serial clocks, for each command kind
  function automatic int unsigned minBits(kind_e k);
    case (k)
      K_WRSR:         return 16;
      K_SERA, K_BERA: return 32;
      K_PROG:         return 40;
      default:        return 8;
    endcase
  endfunction

endpackage

// File: rtl/fwp_control.sv
module fwp_control
  import flash_wp_pkg::*;
#(
  parameter int BLK_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             csRise,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [BLK_W-1:0] blkAddr,
  input  logic             wpN,
  input  logic             busy,
  input  logic             wel,
  input  logic [2:0]       bp,
  input  logic             srwd,
  input  logic             deepPd,
  input  logic             puwDone,
  output strobe_t          stb
);

  localparam int unsigned NBLK = 32'd1 << BLK_W;

  kind_e       kind;
  logic        lenOk;
  logic        modKind;
  logic        areaCmd;
  logic        areaProt;
  int unsigned protCnt;

  always_comb begin
    case (opcode)
      OP_WREN:          kind = K_WREN;
      OP_WRDI:          kind = K_WRDI;
      OP_WRSR:          kind = K_WRSR;
      OP_PROG:          kind = K_PROG;
      OP_SERA:          kind = K_SERA;
      OP_BERA:          kind = K_BERA;
      OP_CERA, OP_CERB: kind = K_CERA;
      OP_DPD:           kind = K_DPD;
      OP_REL:           kind = K_REL;
      default:          kind = K_NONE;
    endcase
  end

  assign lenOk   = (bitCount[2:0] == 3'b000) && (32'(bitCount) >= minBits(kind));
  assign modKind = (kind == K_WRSR) || (kind == K_PROG) || (kind == K_SERA) ||
                   (kind == K_BERA) || (kind == K_CERA);
  assign areaCmd = (kind == K_PROG) || (kind == K_SERA) || (kind == K_BERA);

  // Number of top blocks guarded by the area-protect value
  always_comb begin
    if (bp == 3'd0)      protCnt = 0;
    else if (bp == 3'd7) protCnt = NBLK;
    else begin
      protCnt = 32'd1 << (bp - 3'd1);
      if (protCnt > NBLK) protCnt = NBLK;
    end
  end

  assign areaProt = (protCnt != 0) && (32'(blkAddr) >= NBLK - protCnt);

  // Gates in series: first failing gate rejects
  always_comb begin
    stb       = '0;
    stb.scope = SCOPE_SECTOR;
    if (csRise && kind != K_NONE) begin
      if (deepPd && kind != K_REL)                        stb.reject = 1'b1;
      else if (!lenOk)                                    stb.reject = 1'b1;
      else if (modKind && (!wel || !puwDone || busy))     stb.reject = 1'b1;
      else if (areaCmd && areaProt)                       stb.reject = 1'b1;
      else if (kind == K_CERA && bp != 3'd0)              stb.reject = 1'b1;
      else if (kind == K_WRSR && srwd && !wpN)            stb.reject = 1'b1;
      else begin
        stb.grant = 1'b1;
        case (kind)
          K_WREN: stb.setWel = 1'b1;
          K_WRDI: stb.clrWel = 1'b1;
          K_WRSR: begin stb.wrStatus = 1'b1; stb.clrWel = 1'b1; end
          K_PROG: begin stb.prog = 1'b1; stb.clrWel = 1'b1; end
          K_SERA: begin stb.erase = 1'b1; stb.clrWel = 1'b1; stb.scope = SCOPE_SECTOR; end
          K_BERA: begin stb.erase = 1'b1; stb.clrWel = 1'b1; stb.scope = SCOPE_BLOCK; end
          K_CERA: begin stb.erase = 1'b1; stb.clrWel = 1'b1; stb.scope = SCOPE_CHIP; end
          K_DPD:  stb.enterDp = 1'b1;
          K_REL:  stb.exitDp = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/fwp_datapath.sv
module fwp_datapath
  import flash_wp_pkg::*;
#(
  parameter int PUW_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    stb,
  input  logic [2:0] newBp,
  input  logic       newSrwd,
  output logic       wel,
  output logic [2:0] bp,
  output logic       srwd,
  output logic       deepPd,
  output logic       puwDone,
  output logic       grant,
  output logic       reject,
  output logic       progStart,
  output logic       eraseStart,
  output logic [1:0] eraseScope
);

  localparam int PUW_W = $clog2(PUW_CYCLES + 1);
  localparam logic [PUW_W-1:0] PUW_LAST = PUW_W'(PUW_CYCLES);

  logic [PUW_W-1:0] puwCnt;

  assign puwDone = (puwCnt == PUW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        puwCnt <= '0;
    else if (!puwDone) puwCnt <= puwCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      bp     <= 3'd0;
      srwd   <= 1'b0;
      deepPd <= 1'b0;
    end else begin
      if (stb.setWel)      wel <= 1'b1;
      else if (stb.clrWel) wel <= 1'b0;
      if (stb.wrStatus) begin
        bp   <= newBp;
        srwd <= newSrwd;
      end
      if (stb.enterDp)     deepPd <= 1'b1;
      else if (stb.exitDp) deepPd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      reject     <= 1'b0;
      progStart  <= 1'b0;
      eraseStart <= 1'b0;
      eraseScope <= 2'd0;
    end else begin
      grant      <= stb.grant;
      reject     <= stb.reject;
      progStart  <= stb.prog;
      eraseStart <= stb.erase;
      eraseScope <= stb.scope;
    end
  end

endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int CNT_W      = 16,
  parameter int PUW_CYCLES = 2000,
  localparam int BLK_W     = ADDR_W - 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csRise,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [BLK_W-1:0] blkAddr,
  input  logic [2:0]       newBp,
  input  logic             newSrwd,
  input  logic             wpN,
  input  logic             busy,
  output logic             grant,
  output logic             reject,
  output logic             progStart,
  output logic             eraseStart,
  output logic [1:0]       eraseScope,
  output logic             wel,
  output logic [2:0]       bpBits,
  output logic             srwd,
  output logic             deepPd
);

  strobe_t stb;
  logic    puwDone;

  fwp_control #(.BLK_W(BLK_W), .CNT_W(CNT_W)) uCtrl (
    .csRise(csRise), .opcode(opcode), .bitCount(bitCount), .blkAddr(blkAddr),
    .wpN(wpN), .busy(busy), .wel(wel), .bp(bpBits), .srwd(srwd),
    .deepPd(deepPd), .puwDone(puwDone), .stb(stb)
  );

  fwp_datapath #(.PUW_CYCLES(PUW_CYCLES)) uData (
    .clk(clk), .rst_n(rst_n), .stb(stb), .newBp(newBp), .newSrwd(newSrwd),
    .wel(wel), .bp(bpBits), .srwd(srwd), .deepPd(deepPd), .puwDone(puwDone),
    .grant(grant), .reject(reject), .progStart(progStart),
    .eraseStart(eraseStart), .eraseScope(eraseScope)
  );

endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int PUW_CYCLES = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wpN,
  input logic       grant,
  input logic       reject,
  input logic       progStart,
  input logic       eraseStart,
  input logic [1:0] eraseScope,
  input logic       wel,
  input logic [2:0] bpBits,
  input logic       srwd,
  input logic       deepPd
);

  localparam int CW = $clog2(PUW_CYCLES + 1);
  localparam logic [CW-1:0] CLAST = CW'(PUW_CYCLES);

  logic [CW-1:0] sinceReset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sinceReset <= '0;
    else if (sinceReset != CLAST) sinceReset <= sinceReset + 1'b1;
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject)); // R2
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (progStart || eraseStart) |-> $past(wel)); // R3
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (progStart || eraseStart) |-> !wel); // R4
  AST_PUW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (progStart || eraseStart) |-> sinceReset == CLAST); // R5
  AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (progStart || eraseStart) |-> !deepPd && !$past(deepPd)); // R7
  AST_CHIP_ERASE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseStart && eraseScope == 2'd2) |-> bpBits == 3'd0); // R9
  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(srwd) && !$past(wpN)) |-> ($stable(bpBits) && $stable(srwd))); // R10
  AST_START_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (progStart || eraseStart) |-> grant); // R11
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({progStart, eraseStart})); // R11

endmodule

bind flash_wp_guard fwp_checker #(.PUW_CYCLES(PUW_CYCLES)) uChk (
  .clk(clk), .rst_n(rst_n), .wpN(wpN), .grant(grant), .reject(reject),
  .progStart(progStart), .eraseStart(eraseStart), .eraseScope(eraseScope),
  .wel(wel), .bpBits(bpBits), .srwd(srwd), .deepPd(deepPd)
);

// File: tb/tb_flash_wp_guard.sv
module tb_flash_wp_guard;

  localparam int ADDR_W = 18;
  localparam int BLK_W  = ADDR_W - 16;
  localparam int NBLK   = 1 << BLK_W;
  localparam int CNT_W  = 16;
  localparam int PUW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csRise = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [CNT_W-1:0] bitCount = '0;
  logic [BLK_W-1:0] blkAddr = '0;
  logic [2:0] newBp = 3'd0;
  logic newSrwd = 1'b0;
  logic wpN = 1'b1;
  logic busy = 1'b0;
  logic grant, reject, progStart, eraseStart, wel, srwd, deepPd;
  logic [1:0] eraseScope;
  logic [2:0] bpBits;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_wp_guard #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PUW_CYCLES(PUW)) dut (
    .clk(clk), .rst_n(rst_n), .csRise(csRise), .opcode(opcode), .bitCount(bitCount),
    .blkAddr(blkAddr), .newBp(newBp), .newSrwd(newSrwd), .wpN(wpN), .busy(busy),
    .grant(grant), .reject(reject), .progStart(progStart), .eraseStart(eraseStart),
    .eraseScope(eraseScope), .wel(wel), .bpBits(bpBits), .srwd(srwd), .deepPd(deepPd)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nErrors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Drive one frame at a falling edge; return at the falling edge where results sit
  task automatic send(input logic [7:0] op, input int bits, input int blk);
    @(negedge clk);
    opcode   = op;
    bitCount = CNT_W'(bits);
    blkAddr  = BLK_W'(blk);
    csRise   = 1'b1;
    @(negedge clk);
    csRise   = 1'b0;
  endtask

  task automatic wrStatus(input int b, input bit s);
    newBp   = 3'(b);
    newSrwd = s;
    send(8'h01, 16, 0);
  endtask

  function automatic bit isProt(input int b, input int blk);
    int pc;
    if (b == 0) pc = 0;
    else if (b == 7) pc = NBLK;
    else pc = (1 << (b - 1)) > NBLK ? NBLK : (1 << (b - 1));
    return (pc != 0) && (blk >= NBLK - pc);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wel", int'(wel), 0);
    chk("R1", "bp", int'(bpBits), 0);
    chk("R1", "srwd", int'(srwd), 0);
    chk("R1", "deepPd", int'(deepPd), 0);
    chk("R1", "pulses", int'({grant, reject, progStart, eraseStart}), 0);

    send(8'h06, 8, 0);
    chk("R3", "wren grant", int'(grant), 1);
    chk("R3", "wel set", int'(wel), 1);
    send(8'h02, 40, 0);
    chk("R5", "prog inside window reject", int'(reject), 1);
    chk("R5", "no progStart", int'(progStart), 0);
    chk("R4", "wel kept on reject", int'(wel), 1);

    repeat (PUW + 4) @(negedge clk);
    send(8'h02, 40, 0);
    chk("R5", "prog after window grant", int'(grant), 1);
    chk("R11", "progStart", int'(progStart), 1);
    chk("R4", "wel cleared by prog", int'(wel), 0);
    @(negedge clk);
    chk("R11", "progStart one cycle", int'(progStart), 0);
    send(8'h02, 40, 0);
    chk("R3", "prog without wel reject", int'(reject), 1);

    send(8'h03, 8, 0);
    chk("R2", "unknown opcode no pulse", int'({grant, reject}), 0);
    chk("R2", "unknown opcode wel", int'(wel), 0);

    send(8'h06, 8, 0);
    send(8'h02, 41, 0);
    chk("R6", "unaligned reject", int'(reject), 1);
    send(8'h02, 32, 0);
    chk("R6", "short prog reject", int'(reject), 1);
    send(8'h06, 12, 0);
    chk("R6", "unaligned wren reject", int'(reject), 1);
    chk("R4", "wel kept", int'(wel), 1);
    send(8'h20, 32, 1);
    chk("R6", "sector erase grant", int'(grant), 1);
    chk("R11", "eraseStart", int'(eraseStart), 1);
    chk("R11", "scope sector", int'(eraseScope), 0);

    send(8'h06, 8, 0);
    send(8'h04, 8, 0);
    chk("R4", "wrdi grant", int'(grant), 1);
    chk("R4", "wel cleared by wrdi", int'(wel), 0);

    send(8'h06, 8, 0);
    busy = 1'b1;
    send(8'hD8, 32, 0);
    chk("R8", "busy reject", int'(reject), 1);
    chk("R8", "busy no start", int'(eraseStart), 0);
    busy = 1'b0;
    chk("R8", "wel kept when busy", int'(wel), 1);

    for (int b = 0; b < 8; b++) begin
      send(8'h06, 8, 0);
      wrStatus(b, 1'b0);
      chk("R10", "bp loaded", int'(bpBits), b);
      for (int blk = 0; blk < NBLK; blk++) begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] op;
          int bits;
          bit exp;
          op   = (k == 0) ? 8'h02 : (k == 1) ? 8'h20 : 8'hD8;
          bits = (k == 0) ? 40 : 32;
          exp  = !isProt(b, blk);
          send(8'h06, 8, 0);
          send(op, bits, blk);
          chk("R9", "area grant", int'(grant), int'(exp));
          chk("R9", "area reject", int'(reject), int'(!exp));
          if (k == 0) chk("R11", "progStart by area", int'(progStart), int'(exp));
          else begin
            chk("R11", "eraseStart by area", int'(eraseStart), int'(exp));
            if (exp) chk("R11", "erase scope", int'(eraseScope), k - 1);
          end
        end
      end
      send(8'h06, 8, 0);
      send((b % 2 == 0) ? 8'h60 : 8'hC7, 8, 0);
      chk("R9", "chip erase grant", int'(grant), int'(b == 0));
      if (b == 0) chk("R11", "scope chip", int'(eraseScope), 2);
      chk("R4", "wel after chip erase", int'(wel), int'(b != 0));
    end

    send(8'h06, 8, 0);
    wrStatus(0, 1'b1);
    chk("R10", "srwd set", int'(srwd), 1);
    send(8'h06, 8, 0);
    wpN = 1'b0;
    wrStatus(5, 1'b0);
    chk("R10", "locked reject", int'(reject), 1);
    chk("R10", "bp unchanged", int'(bpBits), 0);
    chk("R10", "srwd unchanged", int'(srwd), 1);
    chk("R4", "wel kept on locked write", int'(wel), 1);
    wpN = 1'b1;
    wrStatus(5, 1'b0);
    chk("R10", "unlocked grant", int'(grant), 1);
    chk("R10", "bp written", int'(bpBits), 5);
    chk("R10", "srwd cleared", int'(srwd), 0);

    send(8'hB9, 8, 0);
    chk("R7", "enter dp", int'(deepPd), 1);
    send(8'h06, 8, 0);
    chk("R7", "wren in dp reject", int'(reject), 1);
    chk("R7", "wel stays 0", int'(wel), 0);
    send(8'hAB, 12, 0);
    chk("R6", "release unaligned reject", int'(reject), 1);
    send(8'hAB, 8, 0);
    chk("R7", "release grant", int'(grant), 1);
    chk("R7", "dp left", int'(deepPd), 0);
    send(8'h06, 8, 0);
    chk("R7", "wren after release", int'(wel), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule